// File: doc/BRIEF.md
# Serial Real-Time-Clock Register Access Master

This block is the bridge between a host and the serial port of a battery-backed clock core. The port has three wires plus an enable: an enable line, a bit clock, a data line toward the core, and a data line back from the core. The host raises a one-cycle request that carries a direction, a 3-bit register address and, for a write, a 32-bit word. The block then produces every edge on the link. When the command ends it pulses `done`, and for a read it presents the 32-bit word it collected.

The block first drives all link lines low. It waits until the upstream logic reports the link ready, then raises the enable and shifts the frame out most significant bit first. A write sends the data word and then the address. A read sends only the address. A mode slot follows with the enable low, carrying 1 for a write or 0 for a read. A read then clocks in 32 bits. Each half of a bit-clock period lasts `HALF_CYC` system clocks. A request that arrives while a command is running is refused with a one-cycle error flag and is not queued.

Top module: `rtc_serial_master`

## Requirements
- R1: Out of reset and between commands, `sen`, `sclk`, `sdi`, `busy`, `done` and `rej_err` are all low.
- R2: A request taken while idle raises `busy` on the next cycle. `sen`, `sclk` and `sdi` stay low while `link_ready` is low, and `sen` rises on the cycle after `link_ready` is seen high.
- R3: Each bit-clock pulse holds `sclk` low for `HALF_CYC` cycles and then high for `HALF_CYC` cycles. `sdi` does not change while `sclk` is high.
- R4: A write (`req_write`=1) sends, with `sen` high, 35 pulses. The first 32 carry `req_data` bit 31 down to bit 0 and the last 3 carry `req_addr` bit 2 down to bit 0.
- R5: A read (`req_write`=0) sends only 3 pulses with `sen` high, carrying `req_addr` bit 2 down to bit 0.
- R6: After the frame comes one mode pulse with `sen` low and `sdi`=1 for a write or `sdi`=0 for a read. After the mode pulse `sdi` is 0.
- R7: After its mode pulse, a read gives 32 more pulses with `sen` low and `sdi` low. `sdo` is sampled in the last cycle of each high phase and shifted in MSB first. The word is on `rd_data` when `done` is high.
- R8: `done` is high for exactly one cycle per command, and `busy` is low on the following cycle. A write makes 36 pulses in total and a read makes 36.
- R9: `req_valid` seen while `busy` is high raises `rej_err` for one cycle on the next cycle. The running command continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle command request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Clock-core register address |
| req_data | input | 32 | Word to write |
| link_ready | input | 1 | Link reported ready by upstream logic |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command strobe |
| rej_err | output | 1 | One-cycle flag: request refused while busy |
| rd_data | output | 32 | Word collected by a read, valid with done |
| sen | output | 1 | Serial enable |
| sclk | output | 1 | Serial bit clock |
| sdi | output | 1 | Serial data toward the core |
| sdo | input | 1 | Serial data from the core |

## Verification
Several properties are checked on every cycle. The link stays quiet while idle, `sdi` holds steady whenever `sclk` is high, and `sen` rises only after `link_ready`. `done` is followed by idle, and a request made while busy is always refused. Other behaviours can only be shown by the bench's scenarios, using a model of the core's side of the link: the exact bit order of write and read frames, the value of the mode slot, the widths of the clock phases, and the word assembled from `sdo`. The same applies to a refused request leaving the frame in progress intact.

// File: rtl/rtc_serial_master.sv
module rtc_serial_master #(
  parameter int HALF_CYC = 500,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              link_ready,
  output logic              busy,
  output logic              done,
  output logic              rej_err,
  output logic [DATA_W-1:0] rd_data,
  output logic              sen,
  output logic              sclk,
  output logic              sdi,
  input  logic              sdo
);
  localparam int FRAME_W = DATA_W + ADDR_W;
  localparam int CNT_W   = $clog2(HALF_CYC + 1);
  localparam int BIT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_SHIFT, S_MODE, S_READ, S_FIN} st_t;

  st_t               st;
  logic              wr, ph, sen_q, rej_q;
  logic [FRAME_W-1:0] sreg;
  logic [BIT_W-1:0]  nbits;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rdata;

  wire active    = (st == S_SHIFT) || (st == S_MODE) || (st == S_READ);
  wire half_end  = (cnt == CNT_W'(HALF_CYC - 1));
  wire pulse_end = active && ph && half_end;
  wire last_bit  = (nbits == BIT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      wr    <= 1'b0;
      ph    <= 1'b0;
      cnt   <= '0;
      sen_q <= 1'b0;
      rej_q <= 1'b0;
      sreg  <= '0;
      nbits <= '0;
      rdata <= '0;
    end else begin
      rej_q <= req_valid && (st != S_IDLE);
      if (active) begin
        if (half_end) begin
          cnt <= '0;
          ph  <= ~ph;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
      case (st)
        S_IDLE: if (req_valid) begin
          wr    <= req_write;
          sreg  <= req_write ? {req_data, req_addr} : {req_addr, {DATA_W{1'b0}}};
          nbits <= req_write ? BIT_W'(FRAME_W) : BIT_W'(ADDR_W);
          cnt   <= '0;
          ph    <= 1'b0;
          st    <= S_WAIT;
        end
        S_WAIT: if (link_ready) begin
          sen_q <= 1'b1;
          st    <= S_SHIFT;
        end
        S_SHIFT: if (pulse_end) begin
          sreg  <= sreg << 1;
          nbits <= nbits - BIT_W'(1);
          if (last_bit) begin
            sen_q <= 1'b0;
            st    <= S_MODE;
          end
        end
        S_MODE: if (pulse_end) begin
          if (wr) st <= S_FIN;
          else begin
            nbits <= BIT_W'(DATA_W);
            st    <= S_READ;
          end
        end
        S_READ: if (pulse_end) begin
          rdata <= {rdata[DATA_W-2:0], sdo};
          nbits <= nbits - BIT_W'(1);
          if (last_bit) st <= S_FIN;
        end
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st != S_IDLE);
  assign done    = (st == S_FIN);
  assign rej_err = rej_q;
  assign rd_data = rdata;
  assign sen     = sen_q;
  assign sclk    = active && ph;
  assign sdi     = (st == S_SHIFT) ? sreg[FRAME_W-1] : ((st == S_MODE) ? wr : 1'b0);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sen && !sclk && !sdi));
  // R2
  sen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sen) |-> $past(link_ready));
  // R3
  sdi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdi));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));
  // R9
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> rej_err);
endmodule

// File: tb/rtc_serial_master_tb.sv
module rtc_serial_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, link_ready = 0, sdo = 0;
  logic [2:0] req_addr = 0;
  logic [31:0] req_data = 0;
  logic busy, done, rej_err, sen, sclk, sdi;
  logic [31:0] rd_data;

  int checks = 0, fails = 0;

  rtc_serial_master #(.HALF_CYC(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_data(req_data), .link_ready(link_ready),
    .busy(busy), .done(done), .rej_err(rej_err), .rd_data(rd_data),
    .sen(sen), .sclk(sclk), .sdi(sdi), .sdo(sdo));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic sen_log [0:63];
  logic sdi_log [0:63];
  int npulse = 0, width_err = 0, hi_run = 0, lo_run = 0, sidx = 0;
  logic sclk_prev = 0, gap_ok = 0;
  logic [31:0] slv_word = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk && !sclk_prev) begin
        if (npulse < 64) begin
          sen_log[npulse] = sen;
          sdi_log[npulse] = sdi;
        end
        npulse = npulse + 1;
        if (gap_ok && lo_run != HALF) width_err = width_err + 1;
        hi_run = 1;
      end else if (sclk) hi_run = hi_run + 1;
      if (!sclk && sclk_prev) begin
        if (hi_run != HALF) width_err = width_err + 1;
        lo_run = 1;
        gap_ok = 1;
        if (npulse > 0 && npulse <= 64 && !sen_log[npulse-1]) begin
          if (sidx < 32) sdo = slv_word[31-sidx];
          sidx = sidx + 1;
        end
      end else if (!sclk) lo_run = lo_run + 1;
      if (done) gap_ok = 0;
      sclk_prev = sclk;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    npulse = 0; sidx = 0; width_err = 0; gap_ok = 0;
  endtask

  task automatic issue(input logic w, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    check(req, done, 1);
  endtask

  task automatic t_reset();
    check("R1 sen", sen, 0);
    check("R1 sclk", sclk, 0);
    check("R1 sdi", sdi, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 rej_err", rej_err, 0);
  endtask

  task automatic t_write(input logic [2:0] a, input logic [31:0] d);
    int bad = 0;
    clear_log();
    link_ready = 1;
    issue(1, a, d);
    wait_done("R8 write done");
    for (int k = 0; k < 35; k++) begin
      logic e;
      e = (k < 32) ? d[31-k] : a[2-(k-32)];
      if (sen_log[k] !== 1'b1 || sdi_log[k] !== e) bad++;
    end
    check("R4 write frame bit errors", bad, 0);
    check("R6 write mode sen", sen_log[35], 0);
    check("R6 write mode sdi", sdi_log[35], 1);
    check("R6 sdi after mode", sdi, 0);
    check("R8 write pulse count", npulse, 36);
    check("R3 phase widths", width_err, 0);
    @(negedge clk);
    check("R8 done one cycle", done, 0);
    check("R8 busy falls", busy, 0);
    check("R1 idle sen", sen, 0);
  endtask

  task automatic t_read(input logic [2:0] a, input logic [31:0] w);
    int bad = 0;
    clear_log();
    slv_word = w;
    link_ready = 1;
    issue(0, a, 32'hFFFF_FFFF);
    wait_done("R8 read done");
    for (int k = 0; k < 3; k++)
      if (sen_log[k] !== 1'b1 || sdi_log[k] !== a[2-k]) bad++;
    check("R5 read address bit errors", bad, 0);
    check("R6 read mode sen", sen_log[3], 0);
    check("R6 read mode sdi", sdi_log[3], 0);
    bad = 0;
    for (int k = 4; k < 36; k++)
      if (sen_log[k] !== 1'b0 || sdi_log[k] !== 1'b0) bad++;
    check("R7 read pulse line errors", bad, 0);
    check("R8 read pulse count", npulse, 36);
    check("R7 rd_data", rd_data, w);
    check("R3 phase widths", width_err, 0);
    @(negedge clk);
    check("R8 busy falls after read", busy, 0);
  endtask

  task automatic t_wait_ready();
    clear_log();
    link_ready = 0;
    slv_word = 32'h0000_0001;
    issue(0, 3'd2, 0);
    check("R2 busy after request", busy, 1);
    repeat (10) @(negedge clk);
    check("R2 sen held low", sen, 0);
    check("R2 sclk held low", sclk, 0);
    check("R2 no pulses", npulse, 0);
    link_ready = 1;
    @(negedge clk);
    check("R2 sen after ready", sen, 1);
    wait_done("R2 done");
    check("R7 rd_data small", rd_data, 32'h0000_0001);
    @(negedge clk);
  endtask

  task automatic t_reject();
    int bad = 0;
    clear_log();
    link_ready = 1;
    issue(1, 3'd6, 32'h1357_9BDF);
    repeat (20) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 3'd1; req_data = 0;
    @(negedge clk);
    req_valid = 0;
    check("R9 rej_err raised", rej_err, 1);
    @(negedge clk);
    check("R9 rej_err one cycle", rej_err, 0);
    wait_done("R9 command completes");
    for (int k = 0; k < 35; k++) begin
      logic e;
      e = (k < 32) ? 32'h1357_9BDF >> (31-k) : 3'd6 >> (2-(k-32));
      if (sdi_log[k] !== e) bad++;
    end
    check("R9 frame intact", bad, 0);
    check("R9 pulse count intact", npulse, 36);
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write(3'd5, 32'hA5C3_0F81);
    t_write(3'd0, 32'h0000_0001);
    t_write(3'd7, 32'hFFFF_FFFE);
    t_read(3'd4, 32'hDEAD_BEEF);
    t_read(3'd1, 32'h8000_0001);
    t_wait_ready();
    t_reject();
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule